// File: doc/BRIEF.md
# Serial EEPROM Instruction Controller

This block is the command front end of a three-wire serial memory slave. It samples chip select, serial clock and serial data with the system clock. It waits for a start bit, then collects a two-bit opcode, an address field and, for the two data-carrying commands, a data field. It decodes the seven commands. It keeps a write-enable latch that gates every programming command. When chip select falls after a correctly sized programming command, it drives the memory array's write port and starts a self-timed programming cycle.

The programming cycle is modelled by a counter of system clocks. While chip select is high, the serial output pin reports busy (0) during the cycle and ready (1) afterwards. The organisation input picks 16-bit words (6 address bits) or 8-bit bytes (7 address bits). The read data path is outside this block: a read only raises a strobe with the decoded address. The reset input stands in for power-on detection.

Top module: `sermem_cmd_ctrl`

## Requirements
- R1: A command begins at the first sampled serial-clock rise with chip select high and data in at 1. Zero bits clocked in before it are ignored.
- R2: The two bits after the start bit are the opcode: 10 read, 01 write, 11 erase, 00 special. For a special command the two most significant address bits select the function: 11 enable programming, 00 disable programming, 10 erase all, 01 write all.
- R3: The address is 6 bits when `org_wide`=1 and 7 bits when `org_wide`=0, sent MSB first. A read pulses `rd_stb` once, with `mem_addr` equal to the address, as soon as the last address bit is in. `rd_stb` and `wr_stb` never pulse together.
- R4: Reset clears the write-enable latch. The enable and disable commands change it when chip select falls after them, and it holds its value until the next such command or reset.
- R5: Write, erase, erase-all and write-all do nothing while the latch is clear: no `wr_stb` pulse and no programming cycle.
- R6: A command acts only if chip select falls after exactly start + 2 + address bits, plus 16 or 8 data bits for write and write-all. A frame with any other bit count is discarded.
- R7: Each executed programming command gives one `wr_stb` pulse with `wr_wide` set to the organisation. `wr_kind` is 0 for replace with `wr_data` (write), 1 for set to all ones (erase and erase-all) and 2 for AND with `wr_data` (write-all). `wr_all`=1 means every location. In 8-bit mode the data sits in `wr_data[7:0]`.
- R8: A programming cycle lasts PROG_CYCLES clocks. During it, while chip select is high, `sdo_oe`=1 and `sdo`=0. After it, `sdo_oe`=1 and `sdo`=1 while chip select is high.
- R9: During a programming cycle, start bits and whole frames are ignored.
- R10: The ready indication is cleared by a new start bit, or when chip select goes low after the cycle. After that, `sdo_oe`=0.
- R11: A read is never blocked by the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on substitute) |
| org_wide | input | 1 | Organisation: 1 = 16-bit words, 0 = 8-bit bytes |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Ready/busy status bit |
| sdo_oe | output | 1 | Status drive enable |
| rd_stb | output | 1 | Read address valid pulse |
| wr_stb | output | 1 | Array write pulse |
| wr_kind | output | 2 | Write kind: 0 replace, 1 ones, 2 AND |
| wr_all | output | 1 | Apply to every location |
| wr_wide | output | 1 | Organisation of this write |
| mem_addr | output | 7 | Location address for read or write |
| wr_data | output | 16 | Write data, right-aligned |

## Verification
The bench keeps the default 1024-bit geometry and shortens PROG_CYCLES to 200. This lets the sweeps write every one of the 64 words and then every one of the 128 bytes, and poll busy and ready after each write. The cycle is still long enough to clock a whole erase-all frame into the block while it is busy and confirm that the frame is ignored. A scoreboard image is updated only from the write port and compared with an image computed in the bench. Frames one bit long and one bit short, commands sent with programming disabled, and leading zero bits before the start bit complete the corner cases.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        WK_LOAD = 2'd0,
        WK_ONES = 2'd1,
        WK_AND  = 2'd2
    } wkind_e;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SUB_DIS  = 2'b00;
    localparam logic [1:0] SUB_WRAL = 2'b01;
    localparam logic [1:0] SUB_ERAL = 2'b10;
    localparam logic [1:0] SUB_EN   = 2'b11;

endpackage

// File: rtl/sermem_pin_sync.sv
module sermem_pin_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_in,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    // One synchroniser chain per line, plus one extra flop for edge detection.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain_q;
        logic [STAGES:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], pin_in[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign lvl[g]  = chain_q[STAGES-1];
        assign rise[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/sermem_prog_timer.sv
module sermem_prog_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] left_q;
    logic [CW-1:0] left_d;

    always_comb begin
        left_d = left_q;
        if (start)              left_d = LOAD;
        else if (left_q != '0)  left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/sermem_cmd_ctrl.sv
module sermem_cmd_ctrl
    import sermem_pkg::*;
#(
    parameter int MEM_BITS    = 1024,
    parameter int WORD_W      = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PROG_CYCLES = 5000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   org_wide,
    input  logic                                   cs,
    input  logic                                   sclk,
    input  logic                                   sdi,
    output logic                                   sdo,
    output logic                                   sdo_oe,
    output logic                                   rd_stb,
    output logic                                   wr_stb,
    output logic [1:0]                             wr_kind,
    output logic                                   wr_all,
    output logic                                   wr_wide,
    output logic [$clog2(MEM_BITS/BYTE_W)-1:0]     mem_addr,
    output logic [WORD_W-1:0]                      wr_data
);
    localparam int ADDR_W = $clog2(MEM_BITS / BYTE_W);   // byte mode address bits
    localparam int W16_A  = $clog2(MEM_BITS / WORD_W);   // word mode address bits
    localparam int CNT_W  = $clog2(2 + ADDR_W + WORD_W + 2);

    localparam logic [CNT_W-1:0] LEN_A16 = CNT_W'(2 + W16_A);
    localparam logic [CNT_W-1:0] LEN_A8  = CNT_W'(2 + ADDR_W);
    localparam logic [CNT_W-1:0] LEN_D16 = CNT_W'(2 + W16_A + WORD_W);
    localparam logic [CNT_W-1:0] LEN_D8  = CNT_W'(2 + ADDR_W + BYTE_W);

    typedef struct packed {
        phase_e              ph;
        logic                wide;
        logic [1:0]          op;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   data;
        logic [CNT_W-1:0]    cnt;
        logic                wen;
        logic                status;
        logic                rd_sent;
        logic                wr_stb;
        logic                rd_stb;
        wkind_e              kind;
        logic                all;
        logic                pwide;
        logic [ADDR_W-1:0]   paddr;
        logic [WORD_W-1:0]   pdata;
    } ctl_t;

    ctl_t st_q, st_d;

    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic       cs_lvl, cs_fall, sclk_rise, sdi_lvl;
    logic       prog_busy;
    logic       wen_w;

    sermem_pin_sync #(
        .LINES  (3),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in ({sdi, sclk, cs}),
        .lvl    (pin_lvl),
        .rise   (pin_rise),
        .fall   (pin_fall)
    );

    assign cs_lvl    = pin_lvl[0];
    assign cs_fall   = pin_fall[0];
    assign sclk_rise = pin_rise[1];
    assign sdi_lvl   = pin_lvl[2];

    sermem_prog_timer #(
        .CYCLES (PROG_CYCLES)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st_q.wr_stb),
        .busy  (prog_busy)
    );

    logic [CNT_W-1:0] addr_end;
    logic [CNT_W-1:0] need;
    logic [1:0]       sub;
    logic             has_data;

    always_comb begin
        st_d        = st_q;
        st_d.wr_stb = 1'b0;
        st_d.rd_stb = 1'b0;

        addr_end = st_q.wide ? LEN_A16 : LEN_A8;
        sub      = st_q.wide ? st_q.addr[W16_A-1 -: 2] : st_q.addr[ADDR_W-1 -: 2];
        has_data = (st_q.op == OP_WRITE) || (st_q.op == OP_SPECIAL && sub == SUB_WRAL);
        need     = has_data ? (st_q.wide ? LEN_D16 : LEN_D8) : addr_end;

        // frame collection
        if (!cs_lvl) begin
            st_d.ph = PH_IDLE;
        end else if (st_q.ph == PH_IDLE) begin
            if (sclk_rise && sdi_lvl && !prog_busy) begin
                st_d.ph      = PH_SHIFT;
                st_d.wide    = org_wide;
                st_d.op      = '0;
                st_d.addr    = '0;
                st_d.data    = '0;
                st_d.cnt     = '0;
                st_d.rd_sent = 1'b0;
                st_d.status  = 1'b0;
            end
        end else if (sclk_rise) begin
            if (st_q.cnt < CNT_W'(2))
                st_d.op = {st_q.op[0], sdi_lvl};
            else if (st_q.cnt < addr_end)
                st_d.addr = {st_q.addr[ADDR_W-2:0], sdi_lvl};
            else
                st_d.data = {st_q.data[WORD_W-2:0], sdi_lvl};
            if (st_q.cnt != '1)
                st_d.cnt = st_q.cnt + 1'b1;
        end

        // read address hand-off, independent of the enable latch
        if (st_q.ph == PH_SHIFT && st_q.op == OP_READ && st_q.cnt == addr_end && !st_q.rd_sent) begin
            st_d.rd_sent = 1'b1;
            st_d.rd_stb  = 1'b1;
            st_d.paddr   = st_q.addr;
        end

        // execution on deselect
        if (cs_fall && !prog_busy) begin
            st_d.status = 1'b0;
            if (st_q.ph == PH_SHIFT && st_q.cnt == need) begin
                st_d.paddr = st_q.addr;
                st_d.pdata = st_q.data;
                st_d.pwide = st_q.wide;
                unique case (st_q.op)
                    OP_WRITE: begin
                        st_d.wr_stb = st_q.wen;
                        st_d.kind   = WK_LOAD;
                        st_d.all    = 1'b0;
                    end
                    OP_ERASE: begin
                        st_d.wr_stb = st_q.wen;
                        st_d.kind   = WK_ONES;
                        st_d.all    = 1'b0;
                    end
                    OP_SPECIAL: begin
                        unique case (sub)
                            SUB_EN:  st_d.wen = 1'b1;
                            SUB_DIS: st_d.wen = 1'b0;
                            SUB_ERAL: begin
                                st_d.wr_stb = st_q.wen;
                                st_d.kind   = WK_ONES;
                                st_d.all    = 1'b1;
                            end
                            default: begin
                                st_d.wr_stb = st_q.wen;
                                st_d.kind   = WK_AND;
                                st_d.all    = 1'b1;
                            end
                        endcase
                    end
                    default: ;
                endcase
                st_d.status = st_d.wr_stb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.kind <= WK_LOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign wen_w    = st_q.wen;
    assign sdo_oe   = cs_lvl & st_q.status;
    assign sdo      = sdo_oe & ~prog_busy;
    assign rd_stb   = st_q.rd_stb;
    assign wr_stb   = st_q.wr_stb;
    assign wr_kind  = st_q.kind;
    assign wr_all   = st_q.all;
    assign wr_wide  = st_q.pwide;
    assign mem_addr = st_q.paddr;
    assign wr_data  = st_q.pdata;
endmodule

// File: rtl/sermem_cmd_ctrl_chk.sv
module sermem_cmd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_lvl,
    input logic wen,
    input logic busy,
    input logic wr_stb,
    input logic rd_stb,
    input logic sdo_oe
);
    p_prog_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> wen);

    p_busy_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> busy);

    p_status_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> cs_lvl);

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_stb);

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, rd_stb}));

    p_exec_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !cs_lvl);
endmodule

bind sermem_cmd_ctrl sermem_cmd_ctrl_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_lvl (cs_lvl),
    .wen    (wen_w),
    .busy   (prog_busy),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .sdo_oe (sdo_oe)
);

// File: tb/sermem_cmd_ctrl_tb_top.sv
module sermem_cmd_ctrl_tb_top;
    localparam int PROG = 200;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        org_wide = 1'b1;
    logic        cs = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe, rd_stb, wr_stb, wr_all, wr_wide;
    logic [1:0]  wr_kind;
    logic [6:0]  mem_addr;
    logic [15:0] wr_data;

    always #5 clk = ~clk;

    sermem_cmd_ctrl #(.PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .cs(cs), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_kind(wr_kind),
        .wr_all(wr_all), .wr_wide(wr_wide), .mem_addr(mem_addr), .wr_data(wr_data)
    );

    int checks = 0;
    int errors = 0;
    int wr_events = 0;
    int rd_events = 0;
    logic [6:0]    last_rd = '0;
    logic [1023:0] dut_img = '1;
    logic [1023:0] exp_img = '1;
    bit            done = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(logic [1:0] k, logic [15:0] old, logic [15:0] d);
        case (k)
            2'd0:    return d;
            2'd1:    return 16'hFFFF;
            default: return old & d;
        endcase
    endfunction

    // scoreboard fed only from the write port
    always @(negedge clk) begin
        if (wr_stb) begin
            wr_events++;
            if (wr_wide) begin
                for (int w = 0; w < 64; w++)
                    if (wr_all || mem_addr[5:0] == 6'(w))
                        dut_img[16*w +: 16] = merge(wr_kind, dut_img[16*w +: 16], wr_data);
            end else begin
                for (int b = 0; b < 128; b++)
                    if (wr_all || mem_addr == 7'(b))
                        dut_img[8*b +: 8] = merge(wr_kind, {8'h00, dut_img[8*b +: 8]}, wr_data)[7:0];
            end
        end
        if (rd_stb) begin
            rd_events++;
            last_rd = mem_addr;
        end
    end

    function automatic logic [15:0] d16(int a);
        return 16'(a * 16'h0935) ^ 16'h5A3C;
    endfunction

    function automatic logic [7:0] d8(int b);
        return 8'(b * 8'h1D) ^ 8'hA5;
    endfunction

    // builds start + opcode + address (+ data); nb returns the bit count
    function automatic logic [31:0] mk(bit w, logic [1:0] op, logic [6:0] a, logic [15:0] d,
                                       bit hasd, output int nb);
        logic [31:0] v;
        v  = 32'd1;
        v  = (v << 2) | 32'(op);
        if (w) v = (v << 6) | 32'(a[5:0]);
        else   v = (v << 7) | 32'(a);
        nb = 3 + (w ? 6 : 7);
        if (hasd) begin
            if (w) v = (v << 16) | 32'(d);
            else   v = (v << 8) | 32'(d[7:0]);
            nb += (w ? 16 : 8);
        end
        return v;
    endfunction

    function automatic logic [6:0] sub_addr(bit w, logic [1:0] s);
        return w ? {1'b0, s, 4'b0} : {s, 5'b0};
    endfunction

    task automatic shift_bits(int nb, logic [31:0] v);
        for (int i = nb - 1; i >= 0; i--) begin
            sdi = v[i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        sdi = 1'b0;
    endtask

    task automatic frame(int nb, logic [31:0] v);
        cs = 1'b1;
        repeat (HALF) @(negedge clk);
        shift_bits(nb, v);
        repeat (HALF) @(negedge clk);
        cs = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic send(bit w, logic [1:0] op, logic [6:0] a, logic [15:0] d, bit hasd, int adj);
        int nb;
        logic [31:0] v;
        org_wide = w;
        v = mk(w, op, a, d, hasd, nb);
        if (adj > 0)      begin v = v << 1; nb = nb + 1; end
        else if (adj < 0) begin v = v >> 1; nb = nb - 1; end
        frame(nb, v);
    endtask

    // raise select, expect busy, then ready within the cycle time; select stays high
    task automatic poll_ready(string req);
        int n;
        cs = 1'b1;
        repeat (5) @(negedge clk);
        check(sdo_oe === 1'b1 && sdo === 1'b0, req, "busy status", {sdo_oe, sdo}, 2'b10);
        n = 0;
        while (sdo !== 1'b1 && n < PROG + 50) begin
            @(negedge clk);
            n++;
        end
        check(sdo_oe === 1'b1 && sdo === 1'b1, req, "ready status", {sdo_oe, sdo}, 2'b11);
    endtask

    task automatic release_cs();
        cs = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic expect_silent(string req, int ev_before);
        cs = 1'b1;
        repeat (5) @(negedge clk);
        check(sdo_oe === 1'b0, req, "no status after discarded command", sdo_oe, 0);
        check(wr_events == ev_before, req, "no write strobe", wr_events, ev_before);
        release_cs();
    endtask

    task automatic img_check(string req, string what);
        check(dut_img === exp_img, req, what, $countones(dut_img ^ exp_img), 0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        int ev;
        int rv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state (R4)
        check(sdo_oe === 1'b0 && wr_stb === 1'b0 && rd_stb === 1'b0, "R4", "reset outputs",
              {sdo_oe, wr_stb, rd_stb}, 0);

        // R5: programming blocked before enable
        ev = wr_events;
        send(1, 2'b01, 7'd5, 16'h1234, 1, 0);
        expect_silent("R5", ev);
        send(1, 2'b00, sub_addr(1, 2'b10), 16'h0, 0, 0);
        expect_silent("R5", ev);

        // R11 / R3: read while disabled, word mode
        rv = rd_events;
        send(1, 2'b10, 7'h2A, 16'h0, 0, 0);
        check(rd_events == rv + 1 && last_rd == 7'h2A, "R11", "read strobe while disabled",
              last_rd, 7'h2A);

        // R1: leading zeros before start bit, byte mode read
        begin
            int nb;
            logic [31:0] v;
            org_wide = 1'b0;
            v = mk(0, 2'b10, 7'h55, 16'h0, 0, nb);
            rv = rd_events;
            frame(nb + 3, v);
            check(rd_events == rv + 1 && last_rd == 7'h55, "R1", "read after leading zeros",
                  last_rd, 7'h55);
        end

        // R4: enable
        send(1, 2'b00, sub_addr(1, 2'b11), 16'h0, 0, 0);

        // word sweep (R7, R8)
        for (int a = 0; a < 64; a++) begin
            send(1, 2'b01, 7'(a), d16(a), 1, 0);
            exp_img[16*a +: 16] = d16(a);
            poll_ready("R8");
            release_cs();
        end
        img_check("R7", "word sweep image");

        // R2: erase word 3
        send(1, 2'b11, 7'd3, 16'h0, 0, 0);
        exp_img[16*3 +: 16] = 16'hFFFF;
        poll_ready("R8");
        release_cs();
        img_check("R2", "erase one word");

        // R6: one extra bit and one missing bit
        ev = wr_events;
        send(1, 2'b01, 7'd9, 16'h0F0F, 1, 1);
        expect_silent("R6", ev);
        send(1, 2'b01, 7'd9, 16'h0F0F, 1, -1);
        expect_silent("R6", ev);
        img_check("R6", "image after malformed frames");

        // R9: erase-all frame sent during a cycle is ignored
        ev = wr_events;
        send(1, 2'b01, 7'd7, 16'hBEEF, 1, 0);
        exp_img[16*7 +: 16] = 16'hBEEF;
        begin
            int nb;
            logic [31:0] v;
            v = mk(1, 2'b00, sub_addr(1, 2'b10), 16'h0, 0, nb);
            frame(nb, v);
        end
        poll_ready("R9");
        release_cs();
        check(wr_events == ev + 1, "R9", "single strobe across busy frame", wr_events, ev + 1);
        img_check("R9", "image after busy frame");

        // R10: start bit clears ready
        send(1, 2'b11, 7'd3, 16'h0, 0, 0);
        poll_ready("R10");
        begin
            int nb;
            logic [31:0] v;
            v = mk(1, 2'b10, 7'd12, 16'h0, 0, nb);
            rv = rd_events;
            shift_bits(nb, v);
            repeat (4) @(negedge clk);
            check(sdo_oe === 1'b0, "R10", "status cleared by start bit", sdo_oe, 0);
            check(rd_events == rv + 1 && last_rd == 7'd12, "R10", "read in same select",
                  last_rd, 12);
        end
        release_cs();

        // R10: select low clears ready
        send(1, 2'b11, 7'd3, 16'h0, 0, 0);
        poll_ready("R10");
        release_cs();
        cs = 1'b1;
        repeat (5) @(negedge clk);
        check(sdo_oe === 1'b0, "R10", "status cleared by deselect", sdo_oe, 0);
        release_cs();

        // byte sweep (R3, R7)
        for (int b = 0; b < 128; b++) begin
            send(0, 2'b01, 7'(b), {8'h00, d8(b)}, 1, 0);
            exp_img[8*b +: 8] = d8(b);
            poll_ready("R8");
            release_cs();
        end
        img_check("R3", "byte sweep image");

        // write-all in byte mode ANDs every byte (R7)
        send(0, 2'b00, sub_addr(0, 2'b01), 16'h00F0, 1, 0);
        for (int b = 0; b < 128; b++) exp_img[8*b +: 8] = exp_img[8*b +: 8] & 8'hF0;
        poll_ready("R8");
        release_cs();
        img_check("R7", "byte write-all AND");

        // erase-all (R2)
        send(0, 2'b00, sub_addr(0, 2'b10), 16'h0, 0, 0);
        exp_img = '1;
        poll_ready("R8");
        release_cs();
        img_check("R2", "erase-all");

        // write-all in word mode (R7)
        send(1, 2'b00, sub_addr(1, 2'b01), 16'h1248, 1, 0);
        for (int w = 0; w < 64; w++) exp_img[16*w +: 16] = 16'h1248;
        poll_ready("R8");
        release_cs();
        img_check("R7", "word write-all");

        // R4 / R5: disable then write is blocked
        send(0, 2'b00, sub_addr(0, 2'b00), 16'h0, 0, 0);
        ev = wr_events;
        send(0, 2'b01, 7'd20, 16'h0033, 1, 0);
        expect_silent("R4", ev);
        send(0, 2'b11, 7'd20, 16'h0, 0, 0);
        expect_silent("R5", ev);
        img_check("R5", "image unchanged while disabled");

        done = 1'b1;
        summary();
    end
endmodule